// File: doc/BRIEF.md
# Banked Operand Address Resolver with Stack Pointer

This block turns an operand request from an 8-bit controller's decode stage into a physical byte address inside the 256-byte internal data space. It handles five kinds of operand: a banked working register, a direct address, an indirect address taken from a pointer register, a stack push and a stack pop. It also holds the two bank-select bits and the 8-bit stack pointer. Working registers live in four 8-byte windows at the bottom of the space. The bank bits choose the window, so the same register index reaches a different byte after a bank switch.

Most requests finish in a single cycle. An indirect request must first read its pointer byte (register 0 or 1 of the active bank) through a one-cycle-latency RAM read port, so it takes three cycles. A small state machine sequences the work with states IDLE, PTR_RD, PTR_CAP and EMIT. Register, direct, push and pop requests take the IDLE→EMIT transition. Indirect requests take IDLE→PTR_RD, then PTR_RD→PTR_CAP (the read is issued), then PTR_CAP→EMIT (the pointer byte is captured). EMIT→IDLE always follows. The resolved address is presented for exactly one cycle, in EMIT.

Top module: `ora_resolver`

## Requirements
- R1: After reset the stack pointer reads 07H, the bank bits read 0, and both `busy` and `addr_valid` are low.
- R2: A register request (kind code 0) with index n yields address {3'b000, bank[1:0], n[2:0]} with `addr_is_sfr` low. `addr_valid` rises in the cycle after the request is accepted.
- R3: When idle and no request is present, `bank_wr` loads `bank_wdata` into the bank bits. The new value is visible on `bank_value` in the next cycle and is used by later register and indirect requests.
- R4: A direct request (kind code 1) passes `req_direct` through unchanged, one cycle after acceptance. `addr_is_sfr` is high exactly when bit 7 of that address is set (80H–FFH), and low for 00H–7FH.
- R5: An indirect request (kind code 2) reads the pointer at {3'b000, bank, 2'b00, req_idx[0]} with `ram_rd_en` high in the first cycle after acceptance. It then emits the byte read as the address, three cycles after acceptance, with `addr_is_sfr` low even when the pointer is 80H or above.
- R6: A push (kind code 3) raises the stack pointer by one and emits the raised value as the address. The first push after reset lands at 08H.
- R7: A pop (kind code 4) emits the current stack pointer as the address and then lowers the pointer by one.
- R8: The pointer wraps modulo 256 without any flag. A push at FFH emits 00H and leaves 00H; a pop at 00H emits 00H and leaves FFH.
- R9: While `busy` is high, new requests, `sp_wr` and `bank_wr` are ignored. No extra address is emitted, and the stack pointer and bank bits keep their values.
- R10: When idle and no request is present, `sp_wr` loads `sp_wdata` into the stack pointer. If `req_valid` is high in the same cycle, both the SP load and the bank load are dropped, and the request uses the old values.
- R11: `addr_valid` is a single-cycle pulse. Requests with kind codes 5–7 are ignored: no pulse follows and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request present |
| req_kind | input | 3 | 0 register, 1 direct, 2 indirect, 3 push, 4 pop |
| req_idx | input | 3 | Register index; bit 0 picks the pointer register for indirect |
| req_direct | input | 8 | Address for direct requests |
| bank_wr | input | 1 | Load bank bits |
| bank_wdata | input | 2 | New bank bits |
| sp_wr | input | 1 | Load stack pointer |
| sp_wdata | input | 8 | New stack pointer |
| ram_rd_en | output | 1 | Pointer-byte read strobe |
| ram_rd_addr | output | 8 | Pointer-byte read address |
| ram_rd_data | input | 8 | Pointer byte, one cycle after the strobe |
| busy | output | 1 | A request is in flight |
| addr_valid | output | 1 | Resolved address valid (one cycle) |
| addr_out | output | 8 | Resolved internal address |
| addr_is_sfr | output | 1 | Direct address falls in the special-register half |
| sp_value | output | 8 | Current stack pointer |
| bank_value | output | 2 | Current bank bits |

## Verification
The bench walks all four banks and checks that register and pointer-register addresses move with the bank bits. A resolver that ignored the bank would keep hitting 00H–07H. Direct addresses at 7FH and 80H probe the special-register boundary, and a pointer byte of C3H checks that indirect results never raise the special-register flag. A design that classified every address ending up in the upper half would wrongly raise it there. The stack cases cover the first push landing at 08H and pop-then-decrement ordering: a design that decremented before reading would emit one byte too low. Wrap in both directions, at FFH and at 00H, is also covered. Finally, the bench drives requests and configuration writes while busy, and together with a request, to catch a design that emits twice or lets a load slip through.

// File: rtl/ora_pkg.sv
package ora_pkg;

    typedef enum logic [2:0] {
        K_REG      = 3'd0,
        K_DIRECT   = 3'd1,
        K_INDIRECT = 3'd2,
        K_PUSH     = 3'd3,
        K_POP      = 3'd4
    } opnd_kind_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PTR_RD  = 2'd1,
        S_PTR_CAP = 2'd2,
        S_EMIT    = 2'd3
    } rsv_state_e;

endpackage

// File: rtl/ora_bank_map.sv
module ora_bank_map #(
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2,
    parameter int IDX_W  = 3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [IDX_W-1:0]  idx,
    input  logic              ri_sel,
    output logic [ADDR_W-1:0] rn_addr,
    output logic [ADDR_W-1:0] ri_addr
);
    localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

    // Working register: bank picks the 8-byte window, index the byte in it.
    assign rn_addr = {{PAD_W{1'b0}}, bank, idx};
    // Pointer register: only entries 0 and 1 of the active window.
    assign ri_addr = {{PAD_W{1'b0}}, bank, {(IDX_W-1){1'b0}}, ri_sel};

endmodule

// File: rtl/ora_stack_ptr.sv
module ora_stack_ptr #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     INIT = 'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] sp,
    output logic [W-1:0] sp_up
);
    logic [W-1:0] sp_q;

    assign sp_up = sp_q + W'(1);
    assign sp    = sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= INIT;
        end else if (inc) begin
            sp_q <= sp_up;
        end else if (dec) begin
            sp_q <= sp_q - W'(1);
        end else if (load) begin
            sp_q <= load_val;
        end
    end

    // R6 / R8: a push step raises the pointer by one, modulo 2^W
    a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> sp_q == W'($past(sp_q) + W'(1)));

    // R7 / R8: a pop step lowers the pointer by one, modulo 2^W
    a_r7_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> sp_q == W'($past(sp_q) - W'(1)));

    // R10: a lone load takes the written value
    a_r10_sp_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !inc && !dec) |=> sp_q == $past(load_val));

    // R9 / R10: the controller never asks for two pointer actions at once
    a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({inc, dec, load}) <= 1);

endmodule

// File: rtl/ora_resolver.sv
module ora_resolver #(
    parameter int                ADDR_W  = 8,
    parameter int                BANK_W  = 2,
    parameter int                IDX_W   = 3,
    parameter logic [ADDR_W-1:0] SP_INIT = 'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [ADDR_W-1:0] req_direct,
    input  logic              bank_wr,
    input  logic [BANK_W-1:0] bank_wdata,
    input  logic              sp_wr,
    input  logic [ADDR_W-1:0] sp_wdata,
    output logic              ram_rd_en,
    output logic [ADDR_W-1:0] ram_rd_addr,
    input  logic [ADDR_W-1:0] ram_rd_data,
    output logic              busy,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_is_sfr,
    output logic [ADDR_W-1:0] sp_value,
    output logic [BANK_W-1:0] bank_value
);
    import ora_pkg::*;

    localparam int SFR_BIT = ADDR_W - 1;
    localparam int WIN_LSB = BANK_W + IDX_W;

    rsv_state_e        state_q, state_d;
    logic [BANK_W-1:0] bank_q;
    logic              ri_sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sfr_q;
    logic [ADDR_W-1:0] sp_cur, sp_up, rn_addr, ri_addr;
    logic              idle, legal_kind, accept, cfg_ok;
    logic              do_push, do_pop, sp_load;

    assign idle       = (state_q == S_IDLE);
    assign legal_kind = (req_kind == K_REG)      || (req_kind == K_DIRECT) ||
                        (req_kind == K_INDIRECT) || (req_kind == K_PUSH)   ||
                        (req_kind == K_POP);
    assign accept     = idle && req_valid && legal_kind;
    assign cfg_ok     = idle && !req_valid;
    assign do_push    = accept && (req_kind == K_PUSH);
    assign do_pop     = accept && (req_kind == K_POP);
    assign sp_load    = cfg_ok && sp_wr;

    ora_bank_map #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W)
    ) u_map (
        .bank    (bank_q),
        .idx     (req_idx),
        .ri_sel  (ri_sel_q),
        .rn_addr (rn_addr),
        .ri_addr (ri_addr)
    );

    ora_stack_ptr #(
        .W    (ADDR_W),
        .INIT (SP_INIT)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (do_push),
        .dec      (do_pop),
        .load     (sp_load),
        .load_val (sp_wdata),
        .sp       (sp_cur),
        .sp_up    (sp_up)
    );

    // Bank-select bits: written only while idle with no request waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (cfg_ok && bank_wr) begin
            bank_q <= bank_wdata;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_d = (req_kind == K_INDIRECT) ? S_PTR_RD : S_EMIT;
                end
            end
            S_PTR_RD:  state_d = S_PTR_CAP;
            S_PTR_CAP: state_d = S_EMIT;
            S_EMIT:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Output register: resolved address and region flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            sfr_q    <= 1'b0;
            ri_sel_q <= 1'b0;
        end else if (accept) begin
            unique case (req_kind)
                K_REG: begin
                    addr_q <= rn_addr;
                    sfr_q  <= 1'b0;
                end
                K_DIRECT: begin
                    addr_q <= req_direct;
                    sfr_q  <= req_direct[SFR_BIT];
                end
                K_INDIRECT: begin
                    sfr_q    <= 1'b0;
                    ri_sel_q <= req_idx[0];
                end
                K_PUSH: begin
                    addr_q <= sp_up;
                    sfr_q  <= 1'b0;
                end
                K_POP: begin
                    addr_q <= sp_cur;
                    sfr_q  <= 1'b0;
                end
                default: begin
                    sfr_q <= 1'b0;
                end
            endcase
        end else if (state_q == S_PTR_CAP) begin
            addr_q <= ram_rd_data;
        end
    end

    assign ram_rd_en   = (state_q == S_PTR_RD);
    assign ram_rd_addr = ri_addr;
    assign busy        = !idle;
    assign addr_valid  = (state_q == S_EMIT);
    assign addr_out    = addr_q;
    assign addr_is_sfr = sfr_q;
    assign sp_value    = sp_cur;
    assign bank_value  = bank_q;

    // R11: the result strobe never lasts two cycles
    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);

    // R9: bank bits hold while a request is in flight
    a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bank_value));

    // R9: stack pointer holds while a request is in flight
    a_r9_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sp_value));

    // R2: a register operand lands in the low window, never flagged special
    a_r2_reg_window: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_kind == K_REG) |=>
            (addr_out[ADDR_W-1:WIN_LSB] == '0) &&
            (addr_out[IDX_W-1:0] == $past(req_idx)) && !addr_is_sfr);

    // R5: the captured pointer byte is emitted as is, with the flag low
    a_r5_ptr_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PTR_CAP) |=>
            addr_valid && !addr_is_sfr && (addr_out == $past(ram_rd_data)));

endmodule

// File: tb/tb_ora_resolver.sv
`timescale 1ns/100ps
module tb_ora_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [2:0] req_idx = 3'd0;
    logic [7:0] req_direct = 8'd0;
    logic       bank_wr = 1'b0;
    logic [1:0] bank_wdata = 2'd0;
    logic       sp_wr = 1'b0;
    logic [7:0] sp_wdata = 8'd0;
    logic       ram_rd_en;
    logic [7:0] ram_rd_addr;
    logic [7:0] ram_rd_data = 8'd0;
    logic       busy, addr_valid, addr_is_sfr;
    logic [7:0] addr_out, sp_value;
    logic [1:0] bank_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] mem [256];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
    end

    ora_resolver dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_idx     (req_idx),
        .req_direct  (req_direct),
        .bank_wr     (bank_wr),
        .bank_wdata  (bank_wdata),
        .sp_wr       (sp_wr),
        .sp_wdata    (sp_wdata),
        .ram_rd_en   (ram_rd_en),
        .ram_rd_addr (ram_rd_addr),
        .ram_rd_data (ram_rd_data),
        .busy        (busy),
        .addr_valid  (addr_valid),
        .addr_out    (addr_out),
        .addr_is_sfr (addr_is_sfr),
        .sp_value    (sp_value),
        .bank_value  (bank_value)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Issue one request; expect a one-cycle pulse after exp_lat cycles.
    task automatic run_req(input logic [2:0] kind, input logic [2:0] idx, input logic [7:0] dir,
                           input int exp_lat, input logic [7:0] exp_addr, input logic exp_sfr,
                           input string tag);
        int lat;
        req_valid = 1'b1; req_kind = kind; req_idx = idx; req_direct = dir;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (kind == 3'd2) begin
            check({tag, " R5 rd_en"}, ram_rd_en, 1'b1);
            check({tag, " R5 rd_addr"}, ram_rd_addr, {3'b000, bank_value, 2'b00, idx[0]});
        end
        while (!addr_valid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " latency"}, lat, exp_lat);
        check({tag, " addr"}, addr_out, exp_addr);
        check({tag, " sfr"}, addr_is_sfr, exp_sfr);
        @(negedge clk);
        check({tag, " R11 pulse ends"}, addr_valid, 1'b0);
    endtask

    task automatic set_bank(input logic [1:0] b);
        bank_wr = 1'b1; bank_wdata = b;
        @(negedge clk);
        bank_wr = 1'b0;
        check("R3 bank load", bank_value, b);
    endtask

    task automatic set_sp(input logic [7:0] v);
        sp_wr = 1'b1; sp_wdata = v;
        @(negedge clk);
        sp_wr = 1'b0;
        check("R10 sp load", sp_value, v);
    endtask

    task automatic t_reset();
        check("R1 sp reset", sp_value, 8'h07);
        check("R1 bank reset", bank_value, 2'd0);
        check("R1 busy reset", busy, 1'b0);
        check("R1 valid reset", addr_valid, 1'b0);
    endtask

    task automatic t_registers();
        for (int b = 0; b < 4; b++) begin
            set_bank(2'(b));
            run_req(3'd0, 3'd0, 8'h00, 1, {3'b000, 2'(b), 3'd0}, 1'b0, "R2 reg r0");
            run_req(3'd0, 3'd7, 8'h00, 1, {3'b000, 2'(b), 3'd7}, 1'b0, "R2 reg r7");
        end
        set_bank(2'd0);
    endtask

    task automatic t_direct();
        run_req(3'd1, 3'd0, 8'h00, 1, 8'h00, 1'b0, "R4 direct 00");
        run_req(3'd1, 3'd0, 8'h7F, 1, 8'h7F, 1'b0, "R4 direct 7F");
        run_req(3'd1, 3'd0, 8'h80, 1, 8'h80, 1'b1, "R4 direct 80");
        run_req(3'd1, 3'd0, 8'hFF, 1, 8'hFF, 1'b1, "R4 direct FF");
        run_req(3'd1, 3'd0, 8'h45, 1, 8'h45, 1'b0, "R4 direct 45");
    endtask

    task automatic t_indirect();
        mem[8'h10] = 8'h65;
        mem[8'h11] = 8'hC3;
        mem[8'h00] = 8'h2A;
        set_bank(2'd2);
        run_req(3'd2, 3'd0, 8'h00, 3, 8'h65, 1'b0, "R5 ind bank2 p0");
        run_req(3'd2, 3'd5, 8'h00, 3, 8'hC3, 1'b0, "R5 ind bank2 p1 high");
        set_bank(2'd0);
        run_req(3'd2, 3'd0, 8'h00, 3, 8'h2A, 1'b0, "R5 ind bank0 p0");
    endtask

    task automatic t_stack();
        run_req(3'd3, 3'd0, 8'h00, 1, 8'h08, 1'b0, "R6 first push");
        check("R6 sp after push", sp_value, 8'h08);
        run_req(3'd3, 3'd0, 8'h00, 1, 8'h09, 1'b0, "R6 second push");
        run_req(3'd4, 3'd0, 8'h00, 1, 8'h09, 1'b0, "R7 pop reads top");
        check("R7 sp after pop", sp_value, 8'h08);
    endtask

    task automatic t_wrap();
        set_sp(8'hFF);
        run_req(3'd3, 3'd0, 8'h00, 1, 8'h00, 1'b0, "R8 push wrap");
        check("R8 sp after push wrap", sp_value, 8'h00);
        run_req(3'd4, 3'd0, 8'h00, 1, 8'h00, 1'b0, "R8 pop at 00");
        check("R8 sp after pop wrap", sp_value, 8'hFF);
    endtask

    task automatic t_busy_ignore();
        int pulses;
        set_bank(2'd1);
        set_sp(8'h20);
        mem[8'h08] = 8'h5A;
        req_valid = 1'b1; req_kind = 3'd2; req_idx = 3'd0;
        @(negedge clk);
        check("R9 busy during indirect", busy, 1'b1);
        req_valid = 1'b1; req_kind = 3'd3;
        sp_wr = 1'b1; sp_wdata = 8'h40;
        bank_wr = 1'b1; bank_wdata = 2'd3;
        @(negedge clk);
        req_valid = 1'b0; sp_wr = 1'b0; bank_wr = 1'b0;
        pulses = 0;
        for (int i = 0; i < 5; i++) begin
            if (addr_valid) begin
                pulses++;
                check("R9 indirect result kept", addr_out, 8'h5A);
            end
            @(negedge clk);
        end
        check("R9 single pulse", pulses, 1);
        check("R9 sp unchanged", sp_value, 8'h20);
        check("R9 bank unchanged", bank_value, 2'd1);
    endtask

    task automatic t_priority();
        req_valid = 1'b1; req_kind = 3'd0; req_idx = 3'd3;
        bank_wr = 1'b1; bank_wdata = 2'd3;
        sp_wr = 1'b1; sp_wdata = 8'h55;
        @(negedge clk);
        req_valid = 1'b0; bank_wr = 1'b0; sp_wr = 1'b0;
        check("R10 request wins valid", addr_valid, 1'b1);
        check("R10 old bank used", addr_out, 8'h0B);
        check("R10 sp load dropped", sp_value, 8'h20);
        check("R10 bank load dropped", bank_value, 2'd1);
        @(negedge clk);
    endtask

    task automatic t_bad_kind();
        for (int k = 5; k < 8; k++) begin
            req_valid = 1'b1; req_kind = 3'(k);
            @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 3; i++) begin
                check("R11 bad kind no valid", addr_valid, 1'b0);
                check("R11 bad kind not busy", busy, 1'b0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stack();
        t_registers();
        t_direct();
        t_indirect();
        t_wrap();
        t_busy_ignore();
        t_priority();
        t_bad_kind();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule